// File: doc/BRIEF.md
# Amplifier Power-Up/Down Sequencer

This block runs the host-side power sequences of a four-channel audio amplifier so that its outputs never click or pop. It drives the amplifier's enable pin directly. Every register change is issued as a field write on a request/acknowledge port. An external serial-bus master carries out each write and acknowledges it. All waits are counted in pulses of a 1 ms tick input.

Three command pulses select the sequence to run: power up into play, park the outputs in three-state, or shut the amplifier down. The power-up sequence precharges the inputs and outputs. It then waits for the input bias to settle. The length of that wait scales with the input coupling capacitance, which is a parameter given in tenths of a microfarad. The sequence can optionally pass through mute before play. A command that does not fit the current state is refused with a one-cycle flag. A small state code tells the host where the sequence stands.

Top module: `amp_seq`

## Requirements
- R1: After reset, amp_en is 0, state_o is OFF (0), wr_req is 0 and cmd_reject is 0.
- R2: A write holds wr_req high, with wr_field and wr_value unchanged, until the cycle in which wr_ack is seen. Each acknowledge completes exactly one write.
- R3: The field codes are: 0 short-circuit threshold (0 raised for start-up, 1 normal), 1 standby, 2 input precharge, 3 output mode (both channel pairs), 4 application settings (value 0). The mode values are 00 three-state, 01 mute, 10 precharge, 11 play. A start-up command sets amp_en first and then writes threshold 0, standby 0, precharge 1, mode 10 and settings 0, in that order.
- R4: Precharge 0 is not requested until PRE_MS+1 ticks have been counted after the precharge 1 write was acknowledged.
- R5: After the precharge 0 write is acknowledged, the next write waits CAP_TENTHS_UF×10+1 ticks. With the default of 22 this is 221 ticks.
- R6: With mute_before_play high at start-up, mode 01 is written, MUTE_MS+1 ticks pass, and then mode 11 and threshold 1 are written. With it low, mode 11 and threshold 1 follow the settle wait directly. The block then reports PLAY.
- R7: A three-state command in PLAY writes mode 01, waits MUTE_MS+1 ticks and writes mode 00. If source_muted is high when the command is taken, only mode 00 is written. The block then reports THREE_STATE.
- R8: A shut-down command in PLAY runs the three-state writes, then writes standby 1. A shut-down command in THREE_STATE writes standby 1 only. After the standby acknowledge, amp_en drops and the block reports OFF.
- R9: Start-up is taken only in OFF, three-state only in PLAY, and shut-down only in PLAY or THREE_STATE. Any other command raises cmd_reject for one cycle, on the cycle after the command, and has no other effect.
- R10: The state_o codes are 0 OFF, 1 STARTING, 2 PLAY, 3 THREE_STATE and 4 STOPPING. STOPPING covers any sequence that leaves PLAY or powers down. The code changes on the cycle after a command is taken.
- R11: When several commands arrive in the same cycle, only one is considered: shut-down wins over three-state, and three-state wins over start-up. The others are dropped without a reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| cmd_start | input | 1 | Power-up command pulse |
| cmd_tri | input | 1 | Three-state command pulse |
| cmd_down | input | 1 | Shut-down command pulse |
| mute_before_play | input | 1 | Pass through mute before play at start-up |
| source_muted | input | 1 | Audio source is already silent, so the mute step is skipped |
| amp_en | output | 1 | Amplifier enable pin |
| wr_req | output | 1 | Field write request |
| wr_field | output | 3 | Field code of the requested write |
| wr_value | output | 2 | Value of the requested write |
| wr_ack | input | 1 | Write acknowledge from the serial master |
| state_o | output | 3 | Sequencer state code |
| cmd_reject | output | 1 | Command refused (one-cycle pulse) |

## Verification
Each accepted command updates state_o and amp_en, and raises the first write request, on the clock edge that samples the command. Each following request appears on the edge that samples the previous acknowledge. A refused command shows cmd_reject on the very next edge. The bench drives inputs and reads outputs on falling edges, so every reject and state check falls exactly one edge after the pulse. Every wait is measured in ticks rather than cycles: the bench stamps the tick total at each acknowledge and at each new request, and requires the difference to equal the exact N+1 count. Ticks that land on an acknowledge edge are excluded, because the block clears its counter there.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

    typedef enum logic [2:0] {
        FLD_SCTH   = 3'd0,
        FLD_STBY   = 3'd1,
        FLD_PRECHG = 3'd2,
        FLD_MODE   = 3'd3,
        FLD_APPCFG = 3'd4
    } fld_e;

    localparam logic [1:0] MODE_TRI    = 2'b00;
    localparam logic [1:0] MODE_MUTE   = 2'b01;
    localparam logic [1:0] MODE_PRECHG = 2'b10;
    localparam logic [1:0] MODE_PLAY   = 2'b11;

    typedef enum logic [2:0] {
        PUB_OFF      = 3'd0,
        PUB_STARTING = 3'd1,
        PUB_PLAY     = 3'd2,
        PUB_TRISTATE = 3'd3,
        PUB_STOPPING = 3'd4
    } pub_e;

    typedef enum logic [4:0] {
        S_OFF, S_SCTH_HI, S_STBY_CLR, S_PRE_SET, S_MODE_PC, S_APPCFG,
        S_WAIT_PRE, S_PRE_CLR, S_WAIT_BIAS, S_MODE_MUTE_UP, S_WAIT_MUTE_UP,
        S_MODE_PLAY, S_SCTH_NORM, S_PLAY, S_MODE_MUTE_DN, S_WAIT_MUTE_DN,
        S_MODE_TRI, S_TRISTATE, S_STBY_SET
    } seq_e;

    typedef enum logic [1:0] {
        CMD_NONE, CMD_START, CMD_TRI, CMD_DOWN
    } cmd_e;

    typedef struct packed {
        seq_e st;
        logic en;
        logic mute_up;
        logic going_down;
        logic reject;
    } regs_t;

endpackage

// File: rtl/amp_seq_timer.sv
module amp_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != '1)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/amp_seq_cmd.sv
module amp_seq_cmd
    import amp_seq_pkg::*;
(
    input  logic go_up,
    input  logic go_tri,
    input  logic go_down,
    output cmd_e sel
);
    always_comb begin
        if (go_down)     sel = CMD_DOWN;
        else if (go_tri) sel = CMD_TRI;
        else if (go_up)  sel = CMD_START;
        else             sel = CMD_NONE;
    end
endmodule

// File: rtl/amp_seq_step.sv
module amp_seq_step
    import amp_seq_pkg::*;
(
    input  seq_e       st,
    output logic       req,
    output fld_e       field,
    output logic [1:0] value
);
    always_comb begin
        req   = 1'b1;
        field = FLD_SCTH;
        value = 2'b00;
        case (st)
            S_SCTH_HI:      begin field = FLD_SCTH;   value = 2'b00;       end
            S_STBY_CLR:     begin field = FLD_STBY;   value = 2'b00;       end
            S_PRE_SET:      begin field = FLD_PRECHG; value = 2'b01;       end
            S_MODE_PC:      begin field = FLD_MODE;   value = MODE_PRECHG; end
            S_APPCFG:       begin field = FLD_APPCFG; value = 2'b00;       end
            S_PRE_CLR:      begin field = FLD_PRECHG; value = 2'b00;       end
            S_MODE_MUTE_UP: begin field = FLD_MODE;   value = MODE_MUTE;   end
            S_MODE_PLAY:    begin field = FLD_MODE;   value = MODE_PLAY;   end
            S_SCTH_NORM:    begin field = FLD_SCTH;   value = 2'b01;       end
            S_MODE_MUTE_DN: begin field = FLD_MODE;   value = MODE_MUTE;   end
            S_MODE_TRI:     begin field = FLD_MODE;   value = MODE_TRI;    end
            S_STBY_SET:     begin field = FLD_STBY;   value = 2'b01;       end
            default:        req = 1'b0;
        endcase
    end
endmodule

// File: rtl/amp_seq.sv
module amp_seq
    import amp_seq_pkg::*;
#(
    parameter int CAP_TENTHS_UF = 22,
    parameter int PRE_MS        = 10,
    parameter int MUTE_MS       = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       cmd_start,
    input  logic       cmd_tri,
    input  logic       cmd_down,
    input  logic       mute_before_play,
    input  logic       source_muted,
    output logic       amp_en,
    output logic       wr_req,
    output logic [2:0] wr_field,
    input  logic       wr_ack,
    output logic [1:0] wr_value,
    output logic [2:0] state_o,
    output logic       cmd_reject
);
    // waits count one extra tick so the real time is never short
    localparam int PRE_N  = PRE_MS + 1;
    localparam int BIAS_N = CAP_TENTHS_UF * 10 + 1;
    localparam int MUTE_N = MUTE_MS + 1;
    localparam int MAX_AB = (PRE_N > BIAS_N) ? PRE_N : BIAS_N;
    localparam int MAX_N  = (MAX_AB > MUTE_N) ? MAX_AB : MUTE_N;
    localparam int TW     = $clog2(MAX_N + 1) + 1;
    localparam logic [TW-1:0] PRE_LIM  = TW'(PRE_N);
    localparam logic [TW-1:0] BIAS_LIM = TW'(BIAS_N);
    localparam logic [TW-1:0] MUTE_LIM = TW'(MUTE_N);

    regs_t r_d, r_q;
    cmd_e  sel;
    logic  step_req;
    fld_e  step_field;
    logic [1:0] step_value;
    logic  t_clr;
    logic [TW-1:0] t_cnt;
    logic  acked;

    amp_seq_cmd u_cmd (
        .go_up   (cmd_start),
        .go_tri  (cmd_tri),
        .go_down (cmd_down),
        .sel     (sel)
    );

    amp_seq_step u_step (
        .st    (r_q.st),
        .req   (step_req),
        .field (step_field),
        .value (step_value)
    );

    amp_seq_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (t_clr),
        .tick  (tick_ms),
        .count (t_cnt)
    );

    assign acked = step_req && wr_ack;

    always_comb begin
        r_d        = r_q;
        r_d.reject = 1'b0;
        t_clr      = 1'b0;
        case (r_q.st)
            S_OFF: begin
                if (sel == CMD_START) begin
                    r_d.st      = S_SCTH_HI;
                    r_d.en      = 1'b1;
                    r_d.mute_up = mute_before_play;
                end else if (sel != CMD_NONE) begin
                    r_d.reject = 1'b1;
                end
            end
            S_PLAY: begin
                if (sel == CMD_DOWN || sel == CMD_TRI) begin
                    r_d.going_down = (sel == CMD_DOWN);
                    r_d.st = source_muted ? S_MODE_TRI : S_MODE_MUTE_DN;
                end else if (sel != CMD_NONE) begin
                    r_d.reject = 1'b1;
                end
            end
            S_TRISTATE: begin
                if (sel == CMD_DOWN) begin
                    r_d.st = S_STBY_SET;
                end else if (sel != CMD_NONE) begin
                    r_d.reject = 1'b1;
                end
            end
            default: begin
                if (sel != CMD_NONE) r_d.reject = 1'b1;
                case (r_q.st)
                    S_SCTH_HI:  if (acked) r_d.st = S_STBY_CLR;
                    S_STBY_CLR: if (acked) r_d.st = S_PRE_SET;
                    S_PRE_SET: begin
                        if (acked) begin
                            r_d.st = S_MODE_PC;
                            t_clr  = 1'b1;
                        end
                    end
                    S_MODE_PC:  if (acked) r_d.st = S_APPCFG;
                    S_APPCFG:   if (acked) r_d.st = S_WAIT_PRE;
                    S_WAIT_PRE: if (t_cnt >= PRE_LIM) r_d.st = S_PRE_CLR;
                    S_PRE_CLR: begin
                        if (acked) begin
                            r_d.st = S_WAIT_BIAS;
                            t_clr  = 1'b1;
                        end
                    end
                    S_WAIT_BIAS: begin
                        if (t_cnt >= BIAS_LIM)
                            r_d.st = r_q.mute_up ? S_MODE_MUTE_UP : S_MODE_PLAY;
                    end
                    S_MODE_MUTE_UP: begin
                        if (acked) begin
                            r_d.st = S_WAIT_MUTE_UP;
                            t_clr  = 1'b1;
                        end
                    end
                    S_WAIT_MUTE_UP: if (t_cnt >= MUTE_LIM) r_d.st = S_MODE_PLAY;
                    S_MODE_PLAY:    if (acked) r_d.st = S_SCTH_NORM;
                    S_SCTH_NORM:    if (acked) r_d.st = S_PLAY;
                    S_MODE_MUTE_DN: begin
                        if (acked) begin
                            r_d.st = S_WAIT_MUTE_DN;
                            t_clr  = 1'b1;
                        end
                    end
                    S_WAIT_MUTE_DN: if (t_cnt >= MUTE_LIM) r_d.st = S_MODE_TRI;
                    S_MODE_TRI: begin
                        if (acked) r_d.st = r_q.going_down ? S_STBY_SET : S_TRISTATE;
                    end
                    S_STBY_SET: begin
                        if (acked) begin
                            r_d.st = S_OFF;
                            r_d.en = 1'b0;
                        end
                    end
                    default: r_d.st = S_OFF;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_OFF, en: 1'b0, mute_up: 1'b0, going_down: 1'b0, reject: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            S_OFF:      state_o = PUB_OFF;
            S_PLAY:     state_o = PUB_PLAY;
            S_TRISTATE: state_o = PUB_TRISTATE;
            S_MODE_MUTE_DN, S_WAIT_MUTE_DN, S_MODE_TRI, S_STBY_SET:
                        state_o = PUB_STOPPING;
            default:    state_o = PUB_STARTING;
        endcase
    end

    assign amp_en     = r_q.en;
    assign wr_req     = step_req;
    assign wr_field   = step_field;
    assign wr_value   = step_value;
    assign cmd_reject = r_q.reject;
endmodule

// File: rtl/amp_seq_chk.sv
module amp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_start,
    input logic       cmd_tri,
    input logic       cmd_down,
    input logic       amp_en,
    input logic       wr_req,
    input logic [2:0] wr_field,
    input logic [1:0] wr_value,
    input logic       wr_ack,
    input logic [2:0] state_o,
    input logic       cmd_reject
);
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_field) && $stable(wr_value)));

    a_r10_en_matches_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> !amp_en);

    a_r10_on_not_off: assert property (@(posedge clk) disable iff (!rst_n)
        amp_en |-> (state_o != 3'd0));

    a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == 3'd1 || state_o == 3'd4) && (cmd_start || cmd_tri || cmd_down))
        |=> cmd_reject);

    a_r7_settled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 || state_o == 3'd2 || state_o == 3'd3) |-> !wr_req);

    a_r6_play_in_startup: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_field == 3'd3 && wr_value == 2'b11) |-> (state_o == 3'd1));

    a_r8_en_after_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(amp_en) |-> ($past(wr_ack) && $past(wr_field) == 3'd1 && $past(wr_value) == 2'b01));
endmodule

bind amp_seq amp_seq_chk u_amp_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_tri    (cmd_tri),
    .cmd_down   (cmd_down),
    .amp_en     (amp_en),
    .wr_req     (wr_req),
    .wr_field   (wr_field),
    .wr_value   (wr_value),
    .wr_ack     (wr_ack),
    .state_o    (state_o),
    .cmd_reject (cmd_reject)
);

// File: tb/amp_seq_bench.sv
module amp_seq_bench;
    localparam int TICK_DIV = 4;
    localparam int PRE_GAP  = 11;
    localparam int BIAS_GAP = 221;
    localparam int MUTE_GAP = 51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b0;
    logic cmd_start = 1'b0, cmd_tri = 1'b0, cmd_down = 1'b0;
    logic mute_before_play = 1'b0, source_muted = 1'b0;
    logic wr_ack = 1'b0;
    logic amp_en, wr_req, cmd_reject;
    logic [2:0] wr_field, state_o;
    logic [1:0] wr_value;

    int n_chk = 0, n_bad = 0;

    logic [2:0] lf   [0:63];
    logic [1:0] lv   [0:63];
    logic       len  [0:63];
    int         lreq [0:63];
    int         lack [0:63];
    int nlog = 0, tot = 0, tdiv = 0, acnt = 0, hs_bad = 0;
    bit pend = 0;

    always #10 clk = ~clk;

    amp_seq u_amp_seq (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .cmd_start(cmd_start), .cmd_tri(cmd_tri), .cmd_down(cmd_down),
        .mute_before_play(mute_before_play), .source_muted(source_muted),
        .amp_en(amp_en), .wr_req(wr_req), .wr_field(wr_field), .wr_ack(wr_ack),
        .wr_value(wr_value), .state_o(state_o), .cmd_reject(cmd_reject)
    );

    // tick source, write responder and write log
    always @(negedge clk) begin
        bit tnow;
        if (rst_n && wr_req && !pend) begin
            if (nlog < 64) begin
                lf[nlog] = wr_field; lv[nlog] = wr_value;
                len[nlog] = amp_en;  lreq[nlog] = tot;
            end
            pend = 1;
        end
        tdiv = tdiv + 1;
        tnow = (tdiv % TICK_DIV == 0);
        tick_ms = tnow;
        tot = tot + (tnow ? 1 : 0);
        if (wr_ack) begin
            wr_ack = 1'b0;
        end else if (pend) begin
            if (acnt == 2) begin
                if (nlog < 64) begin
                    if (wr_field != lf[nlog] || wr_value != lv[nlog] || !wr_req)
                        hs_bad = hs_bad + 1;
                    lack[nlog] = tot;
                end
                wr_ack = 1'b1;
                acnt = 0;
                nlog = nlog + 1;
                pend = 0;
            end else begin
                acnt = acnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic cw(input int i, input int f, input int v, input string r);
        n_chk++;
        if (lf[i] != 3'(f) || lv[i] != 2'(v)) begin
            n_bad++;
            $display("FAIL %s: write %0d actual field=%0d value=%0d expected field=%0d value=%0d",
                     r, i, lf[i], lv[i], f, v);
        end
    endtask

    task automatic pulse(input bit s, input bit t, input bit d);
        @(negedge clk);
        cmd_start = s; cmd_tri = t; cmd_down = d;
        @(negedge clk);
        cmd_start = 1'b0; cmd_tri = 1'b0; cmd_down = 1'b0;
    endtask

    task automatic wait_state(input int s, input string r);
        int k = 0;
        while (state_o != 3'(s) && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(state_o == 3'(s), r, state_o, s);
    endtask

    task automatic t_reset();
        chk(state_o == 3'd0, "R1", state_o, 0);
        chk(amp_en == 1'b0, "R1", amp_en, 0);
        chk(wr_req == 1'b0, "R1", wr_req, 0);
        chk(cmd_reject == 1'b0, "R1", cmd_reject, 0);
        // three-state in OFF is refused and changes nothing
        pulse(0, 1, 0);
        chk(cmd_reject == 1'b1, "R9", cmd_reject, 1);
        chk(state_o == 3'd0 && !wr_req && !amp_en, "R9", state_o, 0);
    endtask

    task automatic t_startup(input bit mute);
        int b = nlog;
        int n;
        mute_before_play = mute;
        pulse(1, 0, 0);
        chk(state_o == 3'd1, "R10", state_o, 1);
        chk(amp_en == 1'b1, "R3", amp_en, 1);
        repeat (20) @(negedge clk);
        pulse(0, 1, 0);
        chk(cmd_reject == 1'b1, "R9", cmd_reject, 1);
        wait_state(2, "R6");
        n = mute ? 9 : 8;
        chk(nlog - b == n, "R6", nlog - b, n);
        chk(len[b] == 1'b1, "R3", len[b], 1);
        cw(b + 0, 0, 0, "R3");
        cw(b + 1, 1, 0, "R3");
        cw(b + 2, 2, 1, "R3");
        cw(b + 3, 3, 2, "R3");
        cw(b + 4, 4, 0, "R3");
        cw(b + 5, 2, 0, "R4");
        chk(lreq[b + 5] - lack[b + 2] == PRE_GAP, "R4", lreq[b + 5] - lack[b + 2], PRE_GAP);
        chk(lreq[b + 6] - lack[b + 5] == BIAS_GAP, "R5", lreq[b + 6] - lack[b + 5], BIAS_GAP);
        if (mute) begin
            cw(b + 6, 3, 1, "R6");
            chk(lreq[b + 7] - lack[b + 6] == MUTE_GAP, "R6", lreq[b + 7] - lack[b + 6], MUTE_GAP);
            cw(b + 7, 3, 3, "R6");
            cw(b + 8, 0, 1, "R6");
        end else begin
            cw(b + 6, 3, 3, "R6");
            cw(b + 7, 0, 1, "R6");
        end
        chk(amp_en == 1'b1, "R6", amp_en, 1);
    endtask

    task automatic t_tristate();
        int b = nlog;
        source_muted = 1'b0;
        pulse(0, 1, 0);
        chk(state_o == 3'd4, "R10", state_o, 4);
        wait_state(3, "R7");
        chk(nlog - b == 2, "R7", nlog - b, 2);
        cw(b, 3, 1, "R7");
        cw(b + 1, 3, 0, "R7");
        chk(lreq[b + 1] - lack[b] == MUTE_GAP, "R7", lreq[b + 1] - lack[b], MUTE_GAP);
    endtask

    task automatic t_down_from_tri();
        int b = nlog;
        // start-up is refused outside OFF
        pulse(1, 0, 0);
        chk(cmd_reject == 1'b1 && state_o == 3'd3, "R9", cmd_reject, 1);
        pulse(0, 0, 1);
        chk(cmd_reject == 1'b0, "R9", cmd_reject, 0);
        wait_state(0, "R8");
        chk(nlog - b == 1, "R8", nlog - b, 1);
        cw(b, 1, 1, "R8");
        chk(amp_en == 1'b0, "R8", amp_en, 0);
    endtask

    task automatic t_play_reject();
        int b = nlog;
        pulse(1, 0, 0);
        chk(cmd_reject == 1'b1, "R9", cmd_reject, 1);
        repeat (5) @(negedge clk);
        chk(state_o == 3'd2 && nlog == b && cmd_reject == 1'b0, "R9", state_o, 2);
    endtask

    task automatic t_prio_tri();
        int b = nlog;
        source_muted = 1'b1;
        pulse(1, 1, 0);
        chk(cmd_reject == 1'b0, "R11", cmd_reject, 0);
        chk(state_o == 3'd4, "R11", state_o, 4);
        wait_state(3, "R7");
        chk(nlog - b == 1, "R7", nlog - b, 1);
        cw(b, 3, 0, "R7");
        source_muted = 1'b0;
    endtask

    task automatic t_prio_down();
        int b = nlog;
        pulse(0, 1, 1);
        chk(cmd_reject == 1'b0, "R11", cmd_reject, 0);
        wait_state(0, "R11");
        chk(nlog - b == 1, "R11", nlog - b, 1);
        cw(b, 1, 1, "R8");
    endtask

    task automatic t_down_from_play();
        int b = nlog;
        source_muted = 1'b0;
        pulse(0, 0, 1);
        chk(state_o == 3'd4, "R10", state_o, 4);
        wait_state(0, "R8");
        chk(nlog - b == 3, "R8", nlog - b, 3);
        cw(b, 3, 1, "R8");
        cw(b + 1, 3, 0, "R8");
        cw(b + 2, 1, 1, "R8");
        chk(lreq[b + 1] - lack[b] == MUTE_GAP, "R8", lreq[b + 1] - lack[b], MUTE_GAP);
        chk(len[b + 2] == 1'b1 && amp_en == 1'b0, "R8", amp_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_startup(1'b0);
        t_tristate();
        t_down_from_tri();
        t_startup(1'b1);
        t_play_reject();
        t_prio_tri();
        t_prio_down();
        t_startup(1'b0);
        t_down_from_play();
        chk(hs_bad == 0, "R2", hs_bad, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule